// File: doc/BRIEF.md
# Home-Node Coherence Directory Controller

This block is the home directory for one memory slice of a four-node distributed shared-memory machine. Every block of the slice has a directory entry: a coherence state (Uncached, Shared or Modified), a vector with one bit per node that holds a copy, and the node that owns the block when it is Modified. The block also holds the slice's data memory. Requesters send read misses, write misses, write hits and data write-backs on a valid/ready request channel. The controller answers with point-to-point messages on a valid/ready message channel: data replies to the requester, invalidates to each sharer, and fetch or fetch-and-invalidate to the current owner.

The controller handles one transaction at a time. After it accepts a request it reads the entry and the data word. It then sends the messages the transaction needs, one per cycle. It commits the new entry before it takes the next request. When the latest data sits in an owner's cache, the controller sends the owner a fetch. It then accepts nothing but that owner's write-back for the same block, writes the returned data into memory and forwards it to the requester. After reset the controller sweeps both memories to zero before it raises ready.

Top module: `home_dir_ctrl`

## Requirements
- R1: After reset, req_ready stays low and msg_valid stays low while the entries are cleared. Afterwards every block is Uncached and every data word reads as zero.
- R2: A read miss (req_kind 0) to an Uncached block yields one data reply (msg_kind 0) to the requester carrying the memory word. The block becomes Shared with only the requester as sharer.
- R3: A read miss to a Shared block yields a data reply with the memory word and adds the requester to the sharers. The state stays Shared.
- R4: A write miss (req_kind 1) to an Uncached block yields a data reply. The block becomes Modified, owned by the requester alone.
- R5: A write miss to a Shared block sends one invalidate (msg_kind 1) to every sharer other than the requester, in ascending node number. It sends one invalidate per cycle while msg_ready is high and never sends one to the requester. It then sends the data reply and leaves the block Modified, owned by the requester.
- R6: A write hit (req_kind 2) from a node that is a sharer of a Shared block invalidates the other sharers and sends no data reply. The writer becomes sole owner in Modified. A write hit in any other situation is handled as a write miss.
- R7: A read miss to a Modified block sends a fetch (msg_kind 2) to the owner. After the owner's write-back (req_kind 3), memory holds the returned word and the requester gets a data reply carrying it. The block becomes Shared with owner and requester as sharers.
- R8: A write miss to a Modified block sends a fetch-and-invalidate (msg_kind 3) to the old owner. After its write-back, the requester gets a data reply carrying the returned word. The block stays Modified with the requester as owner.
- R9: A write-back from the recorded owner of a Modified block writes its data into memory, sends no message and leaves the block Uncached with no sharers.
- R10: While a fetch is outstanding, req_ready is high only for a write-back from the fetched node to the same address. Every other request is held off.
- R11: A write-back from a node that is not the recorded owner, or to a block that is not Modified, is accepted, sends no message and leaves entry and memory unchanged.
- R12: While msg_valid is high and msg_ready is low, msg_valid and all message fields hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted this cycle when high together with req_valid |
| req_kind | input | 2 | 0 read miss, 1 write miss, 2 write hit, 3 data write-back |
| req_node | input | 2 | Sending node |
| req_addr | input | 4 | Block index in this slice |
| req_data | input | 32 | Write-back data |
| msg_valid | output | 1 | Outgoing message present |
| msg_ready | input | 1 | Fabric takes the message this cycle |
| msg_kind | output | 2 | 0 data reply, 1 invalidate, 2 fetch, 3 fetch-and-invalidate |
| msg_node | output | 2 | Destination node |
| msg_addr | output | 4 | Block index |
| msg_data | output | 32 | Reply data (zero for other kinds) |

## Verification
The hardest state to reach from the ports is the wait for an owner's write-back. The entry must first be driven to Modified, and then a read or write miss from another node must arrive, so that a fetch goes out. The bench acts as the owner node. Once it has taken the fetch, it drives a conflicting request for several cycles and checks that it is refused. Only then does it return the write-back with fresh random data and compare the forwarded reply against it. A random mix of all four request kinds on four shared addresses, with random backpressure on the message channel, repeatedly reaches this wait from both the read and the write path. The same mix also produces stray write-backs from nodes that do not own the block.

// File: rtl/dir_pkg.sv
package dir_pkg;

  typedef enum logic [1:0] {
    REQ_RD_MISS    = 2'd0,
    REQ_WR_MISS    = 2'd1,
    REQ_WR_HIT     = 2'd2,
    REQ_WRITE_BACK = 2'd3
  } req_kind_e;

  typedef enum logic [1:0] {
    MSG_DATA      = 2'd0,
    MSG_INV       = 2'd1,
    MSG_FETCH     = 2'd2,
    MSG_FETCH_INV = 2'd3
  } msg_kind_e;

  typedef enum logic [1:0] {
    DS_UNC = 2'd0,
    DS_SHR = 2'd1,
    DS_MOD = 2'd2
  } dir_state_e;

  typedef enum logic [2:0] {
    F_INIT   = 3'd0,
    F_IDLE   = 3'd1,
    F_LOOK   = 3'd2,
    F_INV    = 3'd3,
    F_FWD    = 3'd4,
    F_WAIT   = 3'd5,
    F_REPLY  = 3'd6,
    F_COMMIT = 3'd7
  } fsm_e;

endpackage

// File: rtl/dir_sram.sv
// Simple dual-port memory, one write and one registered read port,
// written so that block RAM can be inferred.
module dir_sram #(
  parameter int W  = 8,
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);
  localparam int DEPTH = 1 << AW;

  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/dir_pick_low.sv
// Index of the lowest set bit of a vector.
module dir_pick_low #(
  parameter int N  = 4,
  parameter int IW = 2
) (
  input  logic [N-1:0]  vec,
  output logic          any,
  output logic [IW-1:0] idx
);
  always_comb begin
    any = 1'b0;
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (vec[i]) begin
        any = 1'b1;
        idx = IW'(i);
      end
    end
  end
endmodule

// File: rtl/home_dir_ctrl.sv
module home_dir_ctrl
  import dir_pkg::*;
#(
  parameter int NODES  = 4,
  parameter int ADDR_W = 4,
  parameter int DATA_W = 32,
  localparam int NW    = $clog2(NODES)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [1:0]        req_kind,
  input  logic [NW-1:0]     req_node,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_data,
  output logic              msg_valid,
  input  logic              msg_ready,
  output logic [1:0]        msg_kind,
  output logic [NW-1:0]     msg_node,
  output logic [ADDR_W-1:0] msg_addr,
  output logic [DATA_W-1:0] msg_data
);
  localparam int ENT_W = 2 + NODES + NW;
  localparam logic [NODES-1:0] ONE_BIT = {{(NODES-1){1'b0}}, 1'b1};

  fsm_e              fsm;
  logic [ADDR_W-1:0] init_ctr;
  logic [1:0]        cur_kind;
  logic [NW-1:0]     cur_node;
  logic [ADDR_W-1:0] cur_addr;
  logic [DATA_W-1:0] cur_data;
  logic [NW-1:0]     fwd_node;
  logic [NODES-1:0]  inv_mask;
  logic              need_reply;
  logic [1:0]        nxt_state;
  logic [NODES-1:0]  nxt_sh;
  logic [NW-1:0]     nxt_own;

  // entry memory
  logic              ent_we;
  logic [ADDR_W-1:0] ent_waddr;
  logic [ENT_W-1:0]  ent_wdata;
  logic [ENT_W-1:0]  ent_rd;
  // data memory
  logic              dat_we;
  logic [ADDR_W-1:0] dat_waddr;
  logic [DATA_W-1:0] dat_wdata;
  logic [DATA_W-1:0] dat_rd;

  logic              req_acc;
  logic              rd_en;
  logic [1:0]        rd_state;
  logic [NODES-1:0]  rd_sh;
  logic [NW-1:0]     rd_own;
  logic [NODES-1:0]  src_bit;
  logic [NODES-1:0]  own_bit;
  logic [NODES-1:0]  inv_cand;
  logic              hit_keep;
  logic              wb_owner_ok;
  logic              pick_any;
  logic [NW-1:0]     pick_idx;

  // ---------------- request side ----------------
  assign req_ready = (fsm == F_IDLE) ||
                     ((fsm == F_WAIT) && (req_kind == REQ_WRITE_BACK) &&
                      (req_node == fwd_node) && (req_addr == cur_addr));
  assign req_acc   = req_valid && req_ready;
  assign rd_en     = (fsm == F_IDLE) && req_valid;

  // ---------------- entry decode ----------------
  assign rd_state    = ent_rd[ENT_W-1 -: 2];
  assign rd_sh       = ent_rd[NW +: NODES];
  assign rd_own      = ent_rd[NW-1:0];
  assign src_bit     = ONE_BIT << cur_node;
  assign own_bit     = ONE_BIT << rd_own;
  assign inv_cand    = (rd_state == DS_SHR) ? (rd_sh & ~src_bit) : '0;
  assign hit_keep    = (cur_kind == REQ_WR_HIT) && (rd_state == DS_SHR) &&
                       rd_sh[cur_node];
  assign wb_owner_ok = (rd_state == DS_MOD) && (rd_own == cur_node);

  // ---------------- memory write ports ----------------
  always_comb begin
    ent_we    = (fsm == F_INIT) || (fsm == F_COMMIT);
    ent_waddr = (fsm == F_INIT) ? init_ctr : cur_addr;
    ent_wdata = (fsm == F_INIT) ? '0 : {nxt_state, nxt_sh, nxt_own};
  end

  always_comb begin
    dat_we    = (fsm == F_INIT) ||
                ((fsm == F_LOOK) && (cur_kind == REQ_WRITE_BACK) && wb_owner_ok) ||
                ((fsm == F_WAIT) && req_acc);
    dat_waddr = (fsm == F_INIT) ? init_ctr : cur_addr;
    if (fsm == F_INIT)      dat_wdata = '0;
    else if (fsm == F_WAIT) dat_wdata = req_data;
    else                    dat_wdata = cur_data;
  end

  dir_sram #(.W(ENT_W), .AW(ADDR_W)) u_ent_ram (
    .clk   (clk),
    .we    (ent_we),
    .waddr (ent_waddr),
    .wdata (ent_wdata),
    .re    (rd_en),
    .raddr (req_addr),
    .rdata (ent_rd)
  );

  dir_sram #(.W(DATA_W), .AW(ADDR_W)) u_dat_ram (
    .clk   (clk),
    .we    (dat_we),
    .waddr (dat_waddr),
    .wdata (dat_wdata),
    .re    (rd_en),
    .raddr (req_addr),
    .rdata (dat_rd)
  );

  dir_pick_low #(.N(NODES), .IW(NW)) u_pick (
    .vec (inv_mask),
    .any (pick_any),
    .idx (pick_idx)
  );

  // ---------------- sequencer ----------------
  always_ff @(posedge clk) begin
    if (rst) begin
      fsm        <= F_INIT;
      init_ctr   <= '0;
      cur_kind   <= '0;
      cur_node   <= '0;
      cur_addr   <= '0;
      cur_data   <= '0;
      fwd_node   <= '0;
      inv_mask   <= '0;
      need_reply <= 1'b0;
      nxt_state  <= '0;
      nxt_sh     <= '0;
      nxt_own    <= '0;
      msg_valid  <= 1'b0;
      msg_kind   <= '0;
      msg_node   <= '0;
      msg_addr   <= '0;
      msg_data   <= '0;
    end else begin
      unique case (fsm)
        F_INIT: begin
          init_ctr <= init_ctr + 1'b1;
          if (&init_ctr) fsm <= F_IDLE;
        end

        F_IDLE: begin
          if (req_valid) begin
            cur_kind <= req_kind;
            cur_node <= req_node;
            cur_addr <= req_addr;
            cur_data <= req_data;
            fsm      <= F_LOOK;
          end
        end

        F_LOOK: begin
          unique case (cur_kind)
            REQ_RD_MISS: begin
              if (rd_state == DS_MOD) begin
                msg_valid <= 1'b1;
                msg_kind  <= MSG_FETCH;
                msg_node  <= rd_own;
                msg_addr  <= cur_addr;
                msg_data  <= '0;
                fwd_node  <= rd_own;
                nxt_state <= DS_SHR;
                nxt_sh    <= own_bit | src_bit;
                nxt_own   <= rd_own;
                fsm       <= F_FWD;
              end else begin
                msg_valid <= 1'b1;
                msg_kind  <= MSG_DATA;
                msg_node  <= cur_node;
                msg_addr  <= cur_addr;
                msg_data  <= dat_rd;
                nxt_state <= DS_SHR;
                nxt_sh    <= ((rd_state == DS_SHR) ? rd_sh : '0) | src_bit;
                nxt_own   <= cur_node;
                fsm       <= F_REPLY;
              end
            end

            REQ_WRITE_BACK: begin
              if (wb_owner_ok) begin
                nxt_state <= DS_UNC;
                nxt_sh    <= '0;
                nxt_own   <= '0;
                fsm       <= F_COMMIT;
              end else begin
                fsm       <= F_IDLE;
              end
            end

            default: begin
              nxt_state <= DS_MOD;
              nxt_sh    <= src_bit;
              nxt_own   <= cur_node;
              if (rd_state == DS_MOD) begin
                msg_valid <= 1'b1;
                msg_kind  <= MSG_FETCH_INV;
                msg_node  <= rd_own;
                msg_addr  <= cur_addr;
                msg_data  <= '0;
                fwd_node  <= rd_own;
                fsm       <= F_FWD;
              end else if (|inv_cand) begin
                inv_mask   <= inv_cand;
                need_reply <= !hit_keep;
                fsm        <= F_INV;
              end else if (!hit_keep) begin
                msg_valid <= 1'b1;
                msg_kind  <= MSG_DATA;
                msg_node  <= cur_node;
                msg_addr  <= cur_addr;
                msg_data  <= dat_rd;
                fsm       <= F_REPLY;
              end else begin
                fsm       <= F_COMMIT;
              end
            end
          endcase
        end

        F_INV: begin
          if (!msg_valid || msg_ready) begin
            if (pick_any) begin
              msg_valid          <= 1'b1;
              msg_kind           <= MSG_INV;
              msg_node           <= pick_idx;
              msg_addr           <= cur_addr;
              msg_data           <= '0;
              inv_mask[pick_idx] <= 1'b0;
            end else if (need_reply) begin
              msg_valid <= 1'b1;
              msg_kind  <= MSG_DATA;
              msg_node  <= cur_node;
              msg_addr  <= cur_addr;
              msg_data  <= dat_rd;
              fsm       <= F_REPLY;
            end else begin
              msg_valid <= 1'b0;
              fsm       <= F_COMMIT;
            end
          end
        end

        F_FWD: begin
          if (msg_ready) begin
            msg_valid <= 1'b0;
            fsm       <= F_WAIT;
          end
        end

        F_WAIT: begin
          if (req_acc) begin
            msg_valid <= 1'b1;
            msg_kind  <= MSG_DATA;
            msg_node  <= cur_node;
            msg_addr  <= cur_addr;
            msg_data  <= req_data;
            fsm       <= F_REPLY;
          end
        end

        F_REPLY: begin
          if (msg_ready) begin
            msg_valid <= 1'b0;
            fsm       <= F_COMMIT;
          end
        end

        F_COMMIT: fsm <= F_IDLE;

        default: fsm <= F_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/dir_ctrl_chk.sv
module dir_ctrl_chk
  import dir_pkg::*;
#(
  parameter int NODES  = 4,
  parameter int ADDR_W = 4,
  parameter int DATA_W = 32,
  localparam int NW    = $clog2(NODES),
  localparam int ENT_W = 2 + NODES + NW
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic              req_ready,
  input logic [1:0]        req_kind,
  input logic [NW-1:0]     req_node,
  input logic [DATA_W-1:0] req_data,
  input logic              msg_valid,
  input logic              msg_ready,
  input logic [1:0]        msg_kind,
  input logic [NW-1:0]     msg_node,
  input logic [ADDR_W-1:0] msg_addr,
  input logic [DATA_W-1:0] msg_data,
  input fsm_e              fsm,
  input logic [NW-1:0]     cur_node,
  input logic [NW-1:0]     fwd_node,
  input logic              ent_we,
  input logic [ENT_W-1:0]  ent_wdata
);
  logic [1:0]       w_state;
  logic [NODES-1:0] w_sh;
  logic [NW-1:0]    w_own;
  logic             commit_w;

  assign w_state  = ent_wdata[ENT_W-1 -: 2];
  assign w_sh     = ent_wdata[NW +: NODES];
  assign w_own    = ent_wdata[NW-1:0];
  assign commit_w = ent_we && (fsm == F_COMMIT);

  p_init_quiet_r1: assert property (@(posedge clk) disable iff (rst)
    (fsm == F_INIT) |-> (!req_ready && !msg_valid));

  p_shared_has_sharer_r2: assert property (@(posedge clk) disable iff (rst)
    (commit_w && w_state == DS_SHR) |-> (w_sh != '0));

  p_modified_one_owner_r4: assert property (@(posedge clk) disable iff (rst)
    (commit_w && w_state == DS_MOD) |-> (($countones(w_sh) == 1) && w_sh[w_own]));

  p_inv_not_requester_r5: assert property (@(posedge clk) disable iff (rst)
    (msg_valid && msg_kind == MSG_INV) |-> (msg_node != cur_node));

  p_reply_forwards_wb_r7: assert property (@(posedge clk) disable iff (rst)
    (fsm == F_WAIT && req_valid && req_ready) |=>
      (msg_valid && msg_kind == MSG_DATA && msg_data == $past(req_data)));

  p_uncached_empty_r9: assert property (@(posedge clk) disable iff (rst)
    (commit_w && w_state == DS_UNC) |-> (w_sh == '0));

  p_wait_blocks_others_r10: assert property (@(posedge clk) disable iff (rst)
    (fsm == F_WAIT && req_valid &&
     (req_node != fwd_node || req_kind != REQ_WRITE_BACK)) |-> !req_ready);

  p_busy_not_ready_r10: assert property (@(posedge clk) disable iff (rst)
    (fsm == F_LOOK || fsm == F_INV || fsm == F_FWD ||
     fsm == F_REPLY || fsm == F_COMMIT) |-> !req_ready);

  p_msg_hold_r12: assert property (@(posedge clk) disable iff (rst)
    (msg_valid && !msg_ready) |=>
      (msg_valid && $stable(msg_kind) && $stable(msg_node) &&
       $stable(msg_addr) && $stable(msg_data)));
endmodule

bind home_dir_ctrl dir_ctrl_chk #(
  .NODES  (NODES),
  .ADDR_W (ADDR_W),
  .DATA_W (DATA_W)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .req_kind  (req_kind),
  .req_node  (req_node),
  .req_data  (req_data),
  .msg_valid (msg_valid),
  .msg_ready (msg_ready),
  .msg_kind  (msg_kind),
  .msg_node  (msg_node),
  .msg_addr  (msg_addr),
  .msg_data  (msg_data),
  .fsm       (fsm),
  .cur_node  (cur_node),
  .fwd_node  (fwd_node),
  .ent_we    (ent_we),
  .ent_wdata (ent_wdata)
);

// File: tb/sim_home_dir_ctrl.sv
`timescale 1ns/1ps
module sim_home_dir_ctrl;
  localparam int N  = 4;
  localparam int AW = 4;
  localparam int DW = 32;
  localparam int NB = 1 << AW;

  logic          clk = 1'b0;
  logic          rst;
  logic          req_valid;
  logic          req_ready;
  logic [1:0]    req_kind;
  logic [1:0]    req_node;
  logic [AW-1:0] req_addr;
  logic [DW-1:0] req_data;
  logic          msg_valid;
  logic          msg_ready;
  logic [1:0]    msg_kind;
  logic [1:0]    msg_node;
  logic [AW-1:0] msg_addr;
  logic [DW-1:0] msg_data;

  always #2.5 clk = ~clk;

  home_dir_ctrl #(.NODES(N), .ADDR_W(AW), .DATA_W(DW)) u0 (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_ready(req_ready), .req_kind(req_kind),
    .req_node(req_node), .req_addr(req_addr), .req_data(req_data),
    .msg_valid(msg_valid), .msg_ready(msg_ready), .msg_kind(msg_kind),
    .msg_node(msg_node), .msg_addr(msg_addr), .msg_data(msg_data)
  );

  int      checks = 0;
  int      errors = 0;
  longint  cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  // reference model: 0 uncached, 1 shared, 2 modified
  int          m_st  [NB];
  logic [3:0]  m_sh  [NB];
  int          m_own [NB];
  logic [31:0] m_mem [NB];

  task automatic chk(string tag, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  task automatic send_req(int k, int n, int a, logic [31:0] d);
    @(negedge clk);
    req_valid = 1'b1;
    req_kind  = 2'(k);
    req_node  = 2'(n);
    req_addr  = AW'(a);
    req_data  = d;
    #1;
    while (!req_ready) begin
      @(negedge clk);
      #1;
    end
    @(posedge clk);
    #1;
    req_valid = 1'b0;
  endtask

  // wait for a message, apply backpressure, check fields at the handshake
  task automatic expect_msg(string tag, int k, int n, int a, logic [31:0] d,
                            bit chk_data, bit strict, output longint when);
    int   guard = 0;
    bit   stalled = 1'b0;
    logic [1:0] s_k;
    logic [1:0] s_n;
    logic [DW-1:0] s_d;
    when = 0;
    forever begin
      @(negedge clk);
      msg_ready = strict ? 1'b1 : (($urandom % 3) != 0);
      #1;
      guard++;
      if (guard > 300) begin
        chk({tag, " message never arrived"}, 0, 1);
        return;
      end
      if (msg_valid) begin
        if (stalled)
          chk("R12 held fields", {msg_kind, msg_node, msg_data}, {s_k, s_n, s_d});
        if (msg_ready) break;
        stalled = 1'b1;
        s_k = msg_kind;
        s_n = msg_node;
        s_d = msg_data;
      end
    end
    when = cyc;
    chk({tag, " kind"}, msg_kind, k);
    chk({tag, " node"}, msg_node, n);
    chk({tag, " addr"}, msg_addr, a);
    if (chk_data) chk({tag, " data"}, msg_data, d);
  endtask

  task automatic quiet(string tag);
    bit seen = 1'b0;
    repeat (8) begin
      @(negedge clk);
      #1;
      if (msg_valid) seen = 1'b1;
    end
    chk({tag, " no message"}, seen, 0);
  endtask

  task automatic txn(int k, int n, int a, logic [31:0] d, bit strict);
    logic [3:0]  invs = '0;
    bit          reply = 1'b0;
    bit          fetch = 1'b0;
    int          fkind = 0;
    logic [31:0] rdata = m_mem[a];
    string       rtag;
    longint      t;
    longint      last_inv;
    bit          had_inv = 1'b0;
    rtag = "R2";
    case (k)
      0: begin
        if (m_st[a] == 2) begin fetch = 1; fkind = 2; rtag = "R7"; end
        else begin reply = 1; rtag = (m_st[a] == 1) ? "R3" : "R2"; end
      end
      1, 2: begin
        if (m_st[a] == 2) begin fetch = 1; fkind = 3; rtag = "R8"; end
        else if (m_st[a] == 1) begin
          invs  = m_sh[a] & ~(4'b1 << n);
          reply = !(k == 2 && m_sh[a][n]);
          rtag  = "R5";
        end else begin reply = 1; rtag = "R4"; end
      end
      default: ;
    endcase

    send_req(k, n, a, d);

    if (k == 3)
      quiet((m_st[a] == 2 && m_own[a] == n) ? "R9 owner write-back" : "R11 stray write-back");
    else if (!fetch && !reply && invs == 0)
      quiet("R6 write hit, no sharers");

    for (int i = 0; i < N; i++) begin
      if (invs[i]) begin
        expect_msg((k == 2 && !reply) ? "R6 invalidate" : "R5 invalidate",
                   1, i, a, '0, 1'b0, strict, t);
        if (strict && had_inv) chk("R5 one invalidate per cycle", t - last_inv, 1);
        last_inv = t;
        had_inv  = 1'b1;
      end
    end

    if (fetch) begin
      expect_msg({rtag, " fetch"}, fkind, m_own[a], a, '0, 1'b0, strict, t);
      // conflicting request while the owner's data is outstanding
      @(negedge clk);
      req_valid = 1'b1;
      req_kind  = 2'd0;
      req_node  = 2'(m_own[a] + 1);
      req_addr  = AW'(a);
      req_data  = '0;
      repeat (3) begin
        @(negedge clk);
        #1;
        chk("R10 other request held off", req_ready, 0);
      end
      req_valid = 1'b0;
      rdata = $urandom;
      send_req(3, m_own[a], a, rdata);
      m_mem[a] = rdata;
    end

    if (reply || fetch)
      expect_msg({rtag, " reply"}, 0, n, a, rdata, 1'b1, strict, t);

    case (k)
      0: begin
        if (m_st[a] == 2) m_sh[a] = (4'b1 << m_own[a]) | (4'b1 << n);
        else m_sh[a] = ((m_st[a] == 1) ? m_sh[a] : 4'b0) | (4'b1 << n);
        m_st[a] = 1;
      end
      1, 2: begin
        m_st[a] = 2; m_sh[a] = 4'b1 << n; m_own[a] = n;
      end
      default: begin
        if (m_st[a] == 2 && m_own[a] == n) begin
          m_mem[a] = d; m_st[a] = 0; m_sh[a] = '0;
        end
      end
    endcase
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not complete actual=hung expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int seen_ready;
    void'($urandom(32'h5eed_c0de));
    for (int i = 0; i < NB; i++) begin
      m_st[i] = 0; m_sh[i] = '0; m_own[i] = 0; m_mem[i] = '0;
    end
    rst = 1'b1;
    req_valid = 1'b0; req_kind = '0; req_node = '0; req_addr = '0; req_data = '0;
    msg_ready = 1'b0;
    repeat (4) @(posedge clk);
    #1;
    rst = 1'b0;

    // R1: clearing sweep keeps both channels quiet, then ready rises
    @(negedge clk);
    chk("R1 ready low during clear", req_ready, 0);
    chk("R1 no message during clear", msg_valid, 0);
    seen_ready = 0;
    for (int i = 0; i < NB + 8 && !seen_ready; i++) begin
      @(negedge clk);
      if (req_ready) seen_ready = 1;
    end
    chk("R1 ready after clear", seen_ready, 1);

    // R1/R2: cleared block returns zero data
    txn(0, 0, 15, '0, 1'b1);
    // R2, R3, R5
    txn(0, 1, 2, '0, 1'b0);
    txn(0, 3, 2, '0, 1'b0);
    txn(0, 0, 2, '0, 1'b0);
    txn(1, 2, 2, '0, 1'b1);
    // R4, R7, R6, R8, R9
    txn(1, 1, 3, '0, 1'b0);
    txn(0, 2, 3, '0, 1'b0);
    txn(2, 2, 3, '0, 1'b1);
    txn(1, 0, 3, '0, 1'b0);
    txn(3, 0, 3, 32'hCAFE_0003, 1'b0);
    txn(0, 3, 3, '0, 1'b0);
    // R11: stray write-back leaves owner in place, next miss fetches from it
    txn(1, 1, 5, '0, 1'b0);
    txn(3, 2, 5, 32'hDEAD_0005, 1'b0);
    txn(0, 3, 5, '0, 1'b0);
    txn(3, 0, 6, 32'h1234_0006, 1'b0);
    txn(0, 0, 6, '0, 1'b0);

    // random mix on four shared blocks
    for (int i = 0; i < 400; i++) begin
      int k = $urandom % 4;
      int n = $urandom % 4;
      int a = $urandom % 4;
      if (k == 3 && m_st[a] == 2 && ($urandom % 2)) n = m_own[a];
      txn(k, n, a, $urandom, ($urandom % 4) == 0);
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule